// File: doc/BRIEF.md
# Statistics Counter Bank with Subtracting Writes

This block holds a small bank of 32-bit event counters. The traffic logic next to it counts events by pulsing one increment strobe per counter. A host reads and writes the counters over a simple word-wide register bus. Reads return the live count and change nothing.

A level input picks how host writes act. With the input low, a write loads the counter with the written word. With it high, the written word is taken off the counter and the result never goes below zero. This lets software subtract what it has already collected without losing events that arrive between its read and its write. An interrupt, gated by an enable bit in a register, is raised while any counter has its top bit set. It stays raised until software brings every such counter back under half range.

When reset is released, the bank runs a fixed start-up window. During that window, increments and host writes are dropped. At the end of the window every counter is cleared.

Top module: `stat_counter_bank`

## Requirements
- R1: A counter whose increment strobe is high on a rising edge counts up by one, and it wraps from FFFF_FFFFh to 0000_0000h. Each counter sits at byte offset 4*i (i = 0..NUM_CNT-1) and responds only to its own strobe bit incStrobe[i].
- R2: With decMode low, a full write to a counter offset loads the written word, so writing zero clears the counter.
- R3: With decMode high, a full write subtracts the written word from the counter. If the written word is larger than the count, the counter becomes zero, so writing FFFF_FFFFh clears it.
- R4: A write is applied only when all four byte enables busBe[3:0] are 1. With any other byte-enable pattern, neither a counter nor the enable register changes.
- R5: When an increment and a host write reach the same counter on the same edge, the write result is formed first and then one is added to it, so the event is not lost.
- R6: statIrq is high exactly while bit 0 of the enable register is 1 and at least one counter is at or above 8000_0000h. The enable register sits at byte offset 80h, resets to 0 and reads back as that bit alone.
- R7: Once raised, statIrq stays high until every counter at or above 8000_0000h has been brought below it by host writes, or until the enable bit is cleared.
- R8: After reset is released, increments and host writes are ignored for CLEAR_DLY (38) rising edges. On the 38th rising edge every counter is cleared to zero, and the bank works normally from then on.
- R9: Reads have no side effect. Any offset other than a counter or the enable register, including a misaligned one, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decMode | input | 1 | 1: writes subtract with a zero floor; 0: writes load |
| incStrobe | input | NUM_CNT | One increment pulse per counter |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 write, 0 read |
| busAddr | input | ADDR_W | Byte address |
| busBe | input | 4 | Byte enables |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Read data, combinational from the address |
| statIrq | output | 1 | Statistics interrupt |

## Verification
Host writes and increment strobes can land on the same counter on the same edge. The bench provokes this by raising a strobe in the same cycle as a subtracting write, and again in the same cycle as a loading write. It then reads the counter back and expects the write result plus one, including the case where a load of all ones plus the increment wraps to zero. A write to a different counter in that cycle must leave the incremented counter one higher.

// File: rtl/stat_pkg.sv
package stat_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CNT  = 2'd1,
    RD_EN   = 2'd2
  } rdKind_e;

  typedef struct packed {
    logic    ready;
    logic    clearAll;
    logic    wrCnt;
    logic    decMode;
    logic    enWrite;
    rdKind_e rdKind;
  } ctrlStrobes_t;

endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import stat_pkg::*;
#(
  parameter int NUM_CNT   = 4,
  parameter int ADDR_W    = 8,
  parameter int CLEAR_DLY = 38,
  parameter int EN_OFF    = 128,
  localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int DLY_W    = $clog2(CLEAR_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decMode,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  output ctrlStrobes_t      strb,
  output logic [IDX_W-1:0]  cntIdx
);

  logic [DLY_W-1:0] dlyCnt;
  logic             readyQ;
  logic             lastDly;
  logic             cntHit;
  logic             enHit;
  logic             fullWr;
  logic [ADDR_W-3:0] wordAddr;

  assign lastDly  = (dlyCnt == DLY_W'(CLEAR_DLY - 1));
  assign wordAddr = busAddr[ADDR_W-1:2];

  // start-up window: count edges after reset release, clear on the last one
  always_ff @(posedge clk) begin
    if (rst) begin
      dlyCnt <= '0;
      readyQ <= 1'b0;
    end else if (!readyQ) begin
      dlyCnt <= dlyCnt + DLY_W'(1);
      if (lastDly) readyQ <= 1'b1;
    end
  end

  always_comb begin
    cntHit = (busAddr[1:0] == 2'b00) && (int'(wordAddr) < NUM_CNT);
    enHit  = (int'(busAddr) == EN_OFF);
    fullWr = busSel && busWr && (busBe == 4'hF) && readyQ;
    cntIdx = wordAddr[IDX_W-1:0];
  end

  always_comb begin
    strb.ready    = readyQ;
    strb.clearAll = !readyQ && lastDly;
    strb.wrCnt    = fullWr && cntHit;
    strb.decMode  = decMode;
    strb.enWrite  = fullWr && enHit;
    if (cntHit)     strb.rdKind = RD_CNT;
    else if (enHit) strb.rdKind = RD_EN;
    else            strb.rdKind = RD_NONE;
  end

  // R4: partial byte enables never yield a write strobe
  a_r4_partial_ignored: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWr && busBe != 4'hF) |-> !(strb.wrCnt || strb.enWrite));

  // R8: no write strobe before the start-up window has ended
  a_r8_no_early_write: assert property (@(posedge clk) disable iff (rst)
    !readyQ |-> !(strb.wrCnt || strb.enWrite));

endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import stat_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 32,
  localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strb,
  input  logic [IDX_W-1:0]   cntIdx,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [NUM_CNT-1:0] incStrobe,
  output logic [CNT_W-1:0]   rdData,
  output logic               statIrq
);

  logic [CNT_W-1:0]   cntQ [NUM_CNT];
  logic [CNT_W-1:0]   cntNxt [NUM_CNT];
  logic [NUM_CNT-1:0] topBits;
  logic               intEnQ;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hitMe;
    logic incMe;
    logic [CNT_W-1:0] afterWr;

    assign hitMe = strb.wrCnt && (cntIdx == IDX_W'(i));
    assign incMe = strb.ready && incStrobe[i];

    always_comb begin
      afterWr = cntQ[i];
      if (hitMe) begin
        if (strb.decMode) afterWr = (cntQ[i] > wrData) ? (cntQ[i] - wrData) : '0;
        else              afterWr = wrData;
      end
      if (strb.clearAll) cntNxt[i] = '0;
      else if (incMe)    cntNxt[i] = afterWr + CNT_W'(1);
      else               cntNxt[i] = afterWr;
    end

    always_ff @(posedge clk) begin
      cntQ[i] <= cntNxt[i];
    end

    assign topBits[i] = cntQ[i][CNT_W-1];

    // R1: increment of the all-ones value wraps to zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
      ($past(incMe) && !$past(hitMe) && !$past(strb.clearAll) && $past(cntQ[i]) == '1)
      |-> cntQ[i] == '0);

    // R3: subtracting more than the count leaves zero
    a_r3_floor: assert property (@(posedge clk) disable iff (rst)
      ($past(hitMe) && $past(strb.decMode) && !$past(incMe) && $past(wrData) >= $past(cntQ[i]))
      |-> cntQ[i] == '0);

    // R5: write and increment together give write result plus one (load case)
    a_r5_collide_load: assert property (@(posedge clk) disable iff (rst)
      ($past(hitMe) && !$past(strb.decMode) && $past(incMe))
      |-> cntQ[i] == $past(wrData) + CNT_W'(1));

    // R8: the start-up clear leaves every counter at zero
    a_r8_cleared: assert property (@(posedge clk) disable iff (rst)
      $past(strb.clearAll) |-> cntQ[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)               intEnQ <= 1'b0;
    else if (strb.enWrite) intEnQ <= wrData[0];
  end

  always_comb begin
    case (strb.rdKind)
      RD_CNT:  rdData = cntQ[cntIdx];
      RD_EN:   rdData = {{(CNT_W-1){1'b0}}, intEnQ};
      default: rdData = '0;
    endcase
  end

  assign statIrq = strb.ready && intEnQ && (|topBits);

  // R7: a raised interrupt stays up unless a host write or a wrapping increment occurred
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(statIrq) && !$past(strb.wrCnt) && !$past(strb.enWrite) && $past(incStrobe) == '0)
    |-> statIrq);

endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_pkg::*;
#(
  parameter int NUM_CNT   = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int CLEAR_DLY = 38,
  parameter int EN_OFF    = 128,
  localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               decMode,
  input  logic [NUM_CNT-1:0] incStrobe,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [3:0]         busBe,
  input  logic [CNT_W-1:0]   busWdata,
  output logic [CNT_W-1:0]   busRdata,
  output logic               statIrq
);

  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] cntIdx;

  stat_ctrl #(
    .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .CLEAR_DLY(CLEAR_DLY), .EN_OFF(EN_OFF)
  ) i_ctrl (
    .clk(clk), .rst(rst), .decMode(decMode), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busBe(busBe), .strb(strb), .cntIdx(cntIdx)
  );

  stat_datapath #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .cntIdx(cntIdx), .wrData(busWdata),
    .incStrobe(incStrobe), .rdData(busRdata), .statIrq(statIrq)
  );

endmodule

// File: tb/test_stat_counter_bank.sv
module test_stat_counter_bank;

  localparam int NUM_CNT = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               decMode = 1'b0;
  logic [NUM_CNT-1:0] incStrobe = '0;
  logic               busSel = 1'b0;
  logic               busWr = 1'b0;
  logic [7:0]         busAddr = '0;
  logic [3:0]         busBe = 4'hF;
  logic [31:0]        busWdata = '0;
  logic [31:0]        busRdata;
  logic               statIrq;

  int nTests = 0;
  int nFail  = 0;

  typedef struct {
    logic [31:0] expData;
    string       tag;
  } expItem_t;
  expItem_t scoreQ[$];
  logic     rdActive = 1'b0;

  always #2.5 clk = ~clk;

  stat_counter_bank i_stat_counter_bank (
    .clk(clk), .rst(rst), .decMode(decMode), .incStrobe(incStrobe),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .statIrq(statIrq)
  );

  // monitor: compare read data against the scoreboard at the falling edge
  always @(negedge clk) begin
    if (rdActive) begin
      expItem_t it;
      if (scoreQ.size() == 0) begin
        nTests++; nFail++;
        $display("FAIL scoreboard empty: got %h expected an item", busRdata);
      end else begin
        it = scoreQ.pop_front();
        nTests++;
        if (busRdata !== it.expData) begin
          nFail++;
          $display("FAIL %s: read %h expected %h", it.tag, busRdata, it.expData);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0; busBe = 4'hF; incStrobe = '0; rdActive = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] be = 4'hF,
                         input logic [NUM_CNT-1:0] inc = '0);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busBe = be;
    incStrobe = inc; rdActive = 1'b0;
    idle();
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.expData = e; it.tag = tag;
    scoreQ.push_back(it);
    @(posedge clk); #1;
    busSel = 1'b1; busWr = 1'b0; busAddr = a; incStrobe = '0; rdActive = 1'b1;
    idle();
  endtask

  task automatic pulseInc(input logic [NUM_CNT-1:0] inc);
    @(posedge clk); #1;
    incStrobe = inc;
    idle();
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    nTests++;
    if (statIrq !== e) begin
      nFail++;
      $display("FAIL %s: statIrq %b expected %b", tag, statIrq, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R8: increments and writes inside the start-up window are dropped
    repeat (5) @(posedge clk);
    #1 incStrobe = 4'hF;
    @(posedge clk); #1 incStrobe = '0;
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h80; busWdata = 32'h1;
    @(posedge clk); #1 busSel = 1'b0; busWr = 1'b0;
    repeat (40) @(posedge clk);
    doRead(8'h00, 32'h0, "R8 counter0 after start-up");
    doRead(8'h0C, 32'h0, "R8 counter3 after start-up");
    doRead(8'h80, 32'h0, "R8 enable still zero");
    checkIrq(1'b0, "R8 irq low after start-up");

    // R1: counting and independence
    pulseInc(4'b0001); pulseInc(4'b0001); pulseInc(4'b0101);
    doRead(8'h00, 32'd3, "R1 counter0 counts");
    doRead(8'h08, 32'd1, "R1 counter2 counts");
    doRead(8'h04, 32'd0, "R1 counter1 untouched");

    // R2: direct load
    decMode = 1'b0;
    doWrite(8'h04, 32'h0000_1234);
    doRead(8'h04, 32'h0000_1234, "R2 load");
    doWrite(8'h04, 32'h0);
    doRead(8'h04, 32'h0, "R2 load zero clears");

    // R1: wrap
    doWrite(8'h0C, 32'hFFFF_FFFF);
    pulseInc(4'b1000);
    doRead(8'h0C, 32'h0, "R1 wrap to zero");

    // R3: subtracting writes
    doWrite(8'h08, 32'd100);
    decMode = 1'b1;
    doWrite(8'h08, 32'd30);
    doRead(8'h08, 32'd70, "R3 subtract");
    doWrite(8'h08, 32'd70);
    doRead(8'h08, 32'd0, "R3 subtract to exact zero");
    decMode = 1'b0; doWrite(8'h08, 32'd50); decMode = 1'b1;
    doWrite(8'h08, 32'd200);
    doRead(8'h08, 32'd0, "R3 floor at zero");
    decMode = 1'b0; doWrite(8'h08, 32'hDEAD_BEEF); decMode = 1'b1;
    doWrite(8'h08, 32'hFFFF_FFFF);
    doRead(8'h08, 32'd0, "R3 all ones clears");

    // R4: partial byte enables ignored
    decMode = 1'b0;
    doWrite(8'h00, 32'd500);
    doWrite(8'h00, 32'd9, 4'b0111);
    doRead(8'h00, 32'd500, "R4 partial write ignored");
    doWrite(8'h80, 32'h1, 4'b0001);
    doRead(8'h80, 32'h0, "R4 partial enable write ignored");

    // R5: collisions
    decMode = 1'b1;
    doWrite(8'h00, 32'd20, 4'hF, 4'b0001);
    doRead(8'h00, 32'd481, "R5 subtract plus increment");
    decMode = 1'b0;
    doWrite(8'h04, 32'd5, 4'hF, 4'b0010);
    doRead(8'h04, 32'd6, "R5 load plus increment");
    doWrite(8'h04, 32'hFFFF_FFFF, 4'hF, 4'b0010);
    doRead(8'h04, 32'd0, "R5 load all ones plus increment wraps");
    doWrite(8'h08, 32'd7, 4'hF, 4'b0001);
    doRead(8'h00, 32'd482, "R5 other counter still increments");
    doRead(8'h08, 32'd7, "R5 written counter loaded");

    // R6 / R7: interrupt
    doWrite(8'h04, 32'h8000_0000);
    checkIrq(1'b0, "R6 irq masked while disabled");
    doWrite(8'h80, 32'h1);
    doRead(8'h80, 32'h1, "R6 enable reads back");
    checkIrq(1'b1, "R6 irq at threshold");
    doWrite(8'h0C, 32'hF000_0000);
    decMode = 1'b1;
    doWrite(8'h04, 32'd1);
    doRead(8'h04, 32'h7FFF_FFFF, "R7 decremented below threshold");
    checkIrq(1'b1, "R7 irq held by second counter");
    repeat (3) @(posedge clk);
    checkIrq(1'b1, "R7 irq stays without writes");
    doWrite(8'h0C, 32'h8000_0000);
    checkIrq(1'b0, "R7 irq cleared after last decrement");
    decMode = 1'b0;
    doWrite(8'h0C, 32'h9000_0000);
    checkIrq(1'b1, "R6 irq raised again");
    doWrite(8'h80, 32'h0);
    checkIrq(1'b0, "R6 irq dropped when disabled");

    // R9: reads and unmapped offsets
    doRead(8'h0C, 32'h9000_0000, "R9 first read");
    doRead(8'h0C, 32'h9000_0000, "R9 repeated read unchanged");
    doRead(8'h10, 32'h0, "R9 unmapped offset");
    doRead(8'h02, 32'h0, "R9 misaligned offset");
    doRead(8'hFC, 32'h0, "R9 top offset");

    repeat (3) @(posedge clk);
    if (scoreQ.size() != 0) begin
      nTests++; nFail++;
      $display("FAIL scoreboard left %0d expected 0", scoreQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule